// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block sits behind a serial memory's command decoder and owns the status register. The decoder hands it three already-decoded events. The first is a write-enable command. The second is a status-register write that carries new nonvolatile bits. The third is a flag saying that a complete, valid write sequence to the memory array has been received. Nothing is committed while chip select is low. The rising edge of chip select closes the sequence, and at that edge the block decides whether to start an internal write cycle.

Hardware protection comes from an active-low protect pin combined with a protect-enable bit. That bit lives inside the same status register it guards. When the enable bit is clear, the pin is ignored. When the enable bit is set and the pin is low at commit time, a status write is refused. Array writes are never gated by the pin.

Once an internal write cycle starts, a fixed-length timer holds a busy flag. During that time the block does not react to chip select or the protect pin, and it ignores every request. When the cycle ends, the write-enable latch clears.

Top module: `sreg_guard`

## Requirements
- R1: After reset, the status output is all zero, and busy and the write-cycle start pulse are low.
- R2: A write-enable request received while chip select is low and the block is idle sets the write-enable latch, status bit 1.
- R3: A status write is committed on the rising edge of chip select. It must be accepted while chip select was low, with the write-enable latch set. The new bits then appear on status bits 7..2, and the start pulse is high for exactly one cycle, together with busy.
- R4: Busy stays high for exactly WR_CYCLES clock cycles after a committed cycle, and status bit 0 mirrors busy.
- R5: The write-enable latch clears when the internal write cycle completes.
- R6: If status bit 7 (protect enable) is 1 and the protect pin is low at commit, a status write is refused. The status bits are unchanged, no cycle starts, and the write-enable latch stays set.
- R7: With the protect pin high, a status write proceeds even when protect enable is 1.
- R8: With protect enable 0, the protect pin has no effect, so a status write succeeds with the pin low.
- R9: The protect pin falling during a busy cycle neither shortens the cycle nor alters the bits already written.
- R10: While busy, write-enable, status-write and valid-sequence requests and chip-select rising edges are ignored. No second cycle starts and the status bits are unchanged.
- R11: A valid array write sequence starts a cycle on the chip-select rise regardless of the protect pin or protect enable. A chip-select rise with no pending request starts nothing.
- R12: A status write made while the write-enable latch is clear is refused and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits a sequence |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_req | input | 1 | Decoded write-enable command, one-cycle pulse |
| sw_req | input | 1 | Decoded status-write command, one-cycle pulse |
| sw_data | input | NV_W | New nonvolatile status bits for a status write |
| seq_ok | input | 1 | Valid array write sequence received, one-cycle pulse |
| status | output | NV_W+2 | {nonvolatile bits, write-enable latch, busy} |
| busy | output | 1 | Internal write cycle in progress |
| wcyc_start | output | 1 | One-cycle pulse when an internal write cycle starts |

## Verification
The bench walks the protect-enable bit through both states and, in each, drives the protect pin both ways at the moment chip select rises. A design that decodes the pin without looking at the enable bit would refuse writes when the enable bit is clear. A design that ignores the pin would let protected writes through. It also drops the pin in the middle of a busy cycle and replays a full request frame during busy. A design that samples the pin continuously, or that lets requests through while busy, would cut the cycle short, overwrite the bits or start a second cycle. Status writes with the write-enable latch clear, and empty chip-select frames, check that nothing starts without a real pending request.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  // Field positions inside the status word.
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;
  localparam int NV_LSB   = 2;

  // Pin protection is active only when the enable bit is set.
  function automatic logic wp_blocks(input logic prot_en, input logic pin_n);
    return prot_en & ~pin_n;
  endfunction

  // Next value of a down counter that stops at zero.
  function automatic int unsigned cnt_next(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction
endpackage

// File: rtl/sreg_edge.sv
module sreg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;
endmodule

// File: rtl/sreg_capture.sv
module sreg_capture #(
  parameter int NV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            cs_rise,
  input  logic            busy,
  input  logic            sw_req,
  input  logic [NV_W-1:0] sw_data,
  input  logic            seq_ok,
  output logic            pend_sw,
  output logic [NV_W-1:0] pend_data,
  output logic            pend_seq
);
  logic open_win;
  assign open_win = ~cs_n & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sw   <= 1'b0;
      pend_seq  <= 1'b0;
      pend_data <= '0;
    end else if (cs_rise) begin
      pend_sw  <= 1'b0;
      pend_seq <= 1'b0;
    end else if (open_win) begin
      if (sw_req) begin
        pend_sw   <= 1'b1;
        pend_data <= sw_data;
      end
      if (seq_ok) pend_seq <= 1'b1;
    end
  end
endmodule

// File: rtl/sreg_timer.sv
module sreg_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= CW'(sreg_pkg::cnt_next(int'(cnt)));
    end
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard #(
  parameter int NV_W      = 6,
  parameter int WR_CYCLES = 16,
  localparam int SR_W     = NV_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wp_n,
  input  logic            wren_req,
  input  logic            sw_req,
  input  logic [NV_W-1:0] sw_data,
  input  logic            seq_ok,
  output logic [SR_W-1:0] status,
  output logic            busy,
  output logic            wcyc_start
);
  import sreg_pkg::*;

  logic            cs_rise;
  logic            pend_sw;
  logic            pend_seq;
  logic [NV_W-1:0] pend_data;
  logic            cyc_done;
  logic            wel;
  logic [NV_W-1:0] nv;
  logic            prot_en;

  // Named events for the checker.
  logic            commit;
  logic            sw_go;
  logic            sw_block;

  sreg_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  sreg_capture #(.NV_W(NV_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cs_rise   (cs_rise),
    .busy      (busy),
    .sw_req    (sw_req),
    .sw_data   (sw_data),
    .seq_ok    (seq_ok),
    .pend_sw   (pend_sw),
    .pend_data (pend_data),
    .pend_seq  (pend_seq)
  );

  assign prot_en  = nv[NV_W-1];
  assign sw_block = cs_rise & ~busy & pend_sw & wp_blocks(prot_en, wp_n);
  assign sw_go    = cs_rise & ~busy & pend_sw & wel & ~wp_blocks(prot_en, wp_n);
  assign commit   = sw_go | (cs_rise & ~busy & pend_seq);

  sreg_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit),
    .busy  (busy),
    .done  (cyc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel        <= 1'b0;
      nv         <= '0;
      wcyc_start <= 1'b0;
    end else begin
      wcyc_start <= commit;
      if (cyc_done)                       wel <= 1'b0;
      else if (wren_req && !cs_n && !busy) wel <= 1'b1;
      if (sw_go) nv <= pend_data;
    end
  end

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy;
    status[WEL_BIT]  = wel;
    status[NV_LSB +: NV_W] = nv;
  end
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
  parameter int NV_W      = 6,
  parameter int WR_CYCLES = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NV_W+1:0] status,
  input logic            busy,
  input logic            wcyc_start,
  input logic            commit,
  input logic            sw_block
);
  logic [31:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start |-> busy);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc_start |=> !wcyc_start);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == WR_CYCLES));

  // R5
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);

  // R9
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[NV_W+1:2]));

  // R6
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_block |=> $stable(status[NV_W+1:2]));

  // R10
  rose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wcyc_start && $past(commit)));
endmodule

bind sreg_guard sreg_guard_chk #(.NV_W(NV_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status     (status),
  .busy       (busy),
  .wcyc_start (wcyc_start),
  .commit     (commit),
  .sw_block   (sw_block)
);

// File: tb/sreg_guard_bench.sv
module sreg_guard_bench;
  localparam int NV_W = 6;
  localparam int WR   = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            wp_n = 1'b1;
  logic            wren_req = 1'b0;
  logic            sw_req = 1'b0;
  logic [NV_W-1:0] sw_data = '0;
  logic            seq_ok = 1'b0;
  logic [NV_W+1:0] status;
  logic            busy;
  logic            wcyc_start;

  int total = 0;
  int bad = 0;
  logic [NV_W-1:0] exp_nv = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  sreg_guard #(.NV_W(NV_W), .WR_CYCLES(WR)) u_sreg_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .wren_req(wren_req), .sw_req(sw_req), .sw_data(sw_data), .seq_ok(seq_ok),
    .status(status), .busy(busy), .wcyc_start(wcyc_start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic w, input logic s, input logic [NV_W-1:0] d, input logic q);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin wren_req = w; sw_req = s; sw_data = d; seq_ok = q; end
    @(negedge clk) begin wren_req = 1'b0; sw_req = 1'b0; seq_ok = 1'b0; cs_n = 1'b1; end
  endtask

  // Follows a committed frame: checks start pulse, busy length, end state.
  // mode 1: drop wp_n mid-cycle; mode 2: replay a request frame while busy.
  task automatic expect_cycle(input string tag, input int mode);
    int hi = 1;
    @(negedge clk);
    check(wcyc_start == 1'b1 && busy == 1'b1 && status[0] == 1'b1, {tag, " start"},
          {wcyc_start, busy, status[0]}, 3'b111);
    check(status[NV_W+1:2] == exp_nv, {tag, " nv"}, status[NV_W+1:2], exp_nv);
    for (int i = 2; i <= WR; i++) begin
      if (mode == 1 && i == 3) wp_n = 1'b0;
      if (mode == 2 && i == 2) cs_n = 1'b0;
      if (mode == 2 && i == 3) begin wren_req = 1; sw_req = 1; sw_data = 6'h3F; seq_ok = 1; end
      if (mode == 2 && i == 4) begin wren_req = 0; sw_req = 0; seq_ok = 0; cs_n = 1'b1; end
      @(negedge clk);
      if (busy && !wcyc_start) hi++;
    end
    check(hi == WR, {tag, " R4 busy length"}, hi, WR);
    @(negedge clk);
    check(busy == 1'b0 && status[1] == 1'b0, {tag, " R5 end busy/wel"},
          {busy, status[1]}, 0);
    check(status[NV_W+1:2] == exp_nv, {tag, " R9 nv after"}, status[NV_W+1:2], exp_nv);
    @(negedge clk);
    check(wcyc_start == 1'b0 && busy == 1'b0, {tag, " R10 no restart"},
          {wcyc_start, busy}, 0);
  endtask

  task automatic expect_none(input string tag, input logic wel_exp);
    @(negedge clk);
    check(wcyc_start == 1'b0 && busy == 1'b0, {tag, " no start"}, {wcyc_start, busy}, 0);
    check(status[1] == wel_exp, {tag, " wel"}, status[1], wel_exp);
    check(status[NV_W+1:2] == exp_nv, {tag, " nv"}, status[NV_W+1:2], exp_nv);
  endtask

  task automatic set_wel();
    frame(1'b1, 1'b0, '0, 1'b0);
    @(negedge clk);
    check(status[1] == 1'b1 && busy == 1'b0, "R2 wel set", status[1], 1);
  endtask

  task automatic t_reset();
    check(status == '0 && busy == 1'b0 && wcyc_start == 1'b0, "R1 reset",
          {status, busy, wcyc_start}, 0);
  endtask

  task automatic t_basic();
    set_wel();
    frame(1'b0, 1'b1, 6'h0A, 1'b0);
    exp_nv = 6'h0A;
    expect_cycle("R3 basic write", 0);
  endtask

  task automatic t_no_wel();
    frame(1'b0, 1'b1, 6'h15, 1'b0);
    expect_none("R12 no wel", 1'b0);
  endtask

  task automatic t_protect();
    wp_n = 1'b1;
    set_wel();
    frame(1'b0, 1'b1, 6'h25, 1'b0);
    exp_nv = 6'h25;
    expect_cycle("R7 pin high pe set", 0);
    set_wel();
    wp_n = 1'b0;
    frame(1'b0, 1'b1, 6'h3F, 1'b0);
    expect_none("R6 refused", 1'b1);
    frame(1'b0, 1'b0, '0, 1'b1);
    expect_cycle("R11 array write protected", 0);
    frame(1'b0, 1'b0, '0, 1'b0);
    expect_none("R11 empty frame", 1'b0);
  endtask

  task automatic t_pe_off();
    wp_n = 1'b1;
    set_wel();
    frame(1'b0, 1'b1, 6'h01, 1'b0);
    exp_nv = 6'h01;
    expect_cycle("R7 clear pe", 0);
    wp_n = 1'b0;
    set_wel();
    frame(1'b0, 1'b1, 6'h13, 1'b0);
    exp_nv = 6'h13;
    expect_cycle("R8 pe off pin low", 0);
  endtask

  task automatic t_mid_wp();
    wp_n = 1'b1;
    set_wel();
    frame(1'b0, 1'b1, 6'h30, 1'b0);
    exp_nv = 6'h30;
    expect_cycle("R9 pin drop busy", 1);
  endtask

  task automatic t_busy_ignore();
    wp_n = 1'b1;
    frame(1'b0, 1'b0, '0, 1'b1);
    expect_cycle("R10 busy requests", 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_wel();
    t_protect();
    t_pe_off();
    t_mid_wp();
    t_busy_ignore();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule